// File: doc/BRIEF.md
# Banked CPU-Interface Control Register

This block holds the control register of an interrupt controller's CPU interface, one per CPU. Each CPU owns two 32-bit copies of the register: a Secure copy (index 0) and a Non-secure copy (index 1). A simple register port carries write and read strobes, a CPU index, a 12-bit offset, 32-bit write data and a non-secure attribute. The register answers only at offset 0x000. Two static inputs select whether security extensions are present and whether the interface follows revision 1 or revision 2 behaviour.

The security configuration, the revision and the security state of each access decide three things: which copy an access reaches, which bits are visible, and whether a write also updates the group-1 enable alias in the other copy. The Secure copy holds the group-1 enable at bit 1. The Non-secure copy holds it at bit 0. In the Secure copy, bit 0 enables group 0, bit 2 is acknowledge control, bit 3 enables FIQ signalling and bit 4 selects the common binary point.

Two enable vectors go to the forwarding logic: one for group 0, taken from Secure bit 0, and one for group 1, taken from Non-secure bit 0. Reads are combinational: read data is valid in the cycle the read strobe is high, and it is zero when no read of the register is in progress.

Top module: `ciface_ctl_bank`

## Requirements
- R1: On reset, both copies of every CPU's register clear to zero. Both enable vectors are then zero, and every read returns zero.
- R2: With security extensions absent and revision 1, every access reaches the Non-secure copy and is masked to bit 0. A write stores wdata & 0x1, a read returns the copy & 0x1, and the non-secure attribute has no effect.
- R3: With security extensions absent and revision 2, every access reaches the Secure copy with mask 0x7FF, and the non-secure attribute has no effect. A write also sets Non-secure bit 0 to the written bit 1.
- R4: With security extensions present, a non-secure access reaches the Non-secure copy with mask 0x261 (bits 0, 5, 6 and 9). Under revision 1 the mask narrows to 0x1, and such a write changes nothing in the Secure copy.
- R5: With security extensions present and revision 2, a non-secure write also sets Secure bit 1 to the written bit 0.
- R6: With security extensions present, a secure access reaches the Secure copy with mask 0x7FF under either revision. A secure write also sets Non-secure bit 0 to the written bit 1.
- R7: grp0_en_o[c] equals Secure bit 0 of CPU c, and grp1_en_o[c] equals Non-secure bit 0 of CPU c. Both change on the clock edge that takes the write.
- R8: A write with a CPU index of N_CPU or above changes nothing, and a read with such an index returns zero.
- R9: A write to any offset other than 0x000 changes nothing, and a read at any other offset returns zero.
- R10: A write to one CPU's register leaves the registers of all other CPUs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_ext_i | input | 1 | Static: security extensions present |
| rev2_i | input | 1 | Static: 1 selects revision 2, 0 selects revision 1 |
| acc_wr_i | input | 1 | Write strobe |
| acc_rd_i | input | 1 | Read strobe |
| acc_cpu_i | input | CPU_IDX_W | CPU index of the access |
| acc_off_i | input | OFF_W | Offset within the CPU interface |
| acc_wdata_i | input | 32 | Write data |
| acc_ns_i | input | 1 | Access is non-secure |
| acc_rdata_o | output | 32 | Read data, combinational |
| grp0_en_o | output | N_CPU | Per-CPU group-0 enable |
| grp1_en_o | output | N_CPU | Per-CPU group-1 enable |

## Verification
The assertions take the configuration inputs as constant while the block is out of reset, because the access class of a write is recomputed from their present values. They also assume that a write and a read never share a cycle. The bench changes configuration only while reset is held, and each access task raises a single strobe. Under those limits the bench sweeps every configuration, both security states, every CPU index (including the out-of-range ones) and several data patterns against a model of both copies.

// File: rtl/ciface_ctl_pkg.sv
package ciface_ctl_pkg;
   localparam int          DATA_W      = 32;
   localparam logic [31:0] SEC_MASK    = 32'h0000_07FF;
   localparam logic [31:0] NSEC_MASK   = 32'h0000_0261;
   localparam logic [31:0] LEGACY_MASK = 32'h0000_0001;

   // access class: which copy, which bits, which alias to keep in step
   typedef struct packed {
      logic              pick_ns;
      logic [DATA_W-1:0] mask;
      logic              alias_to_ns;  // written bit1 -> non-secure bit0
      logic              alias_to_s;   // written bit0 -> secure bit1
   } view_t;
endpackage

// File: rtl/ciface_ctl_view.sv
module ciface_ctl_view
   import ciface_ctl_pkg::*;
(
   input  logic  sec_ext_i,
   input  logic  rev2_i,
   input  logic  ns_i,
   output view_t view_o
);
   always_comb begin
      view_o = '0;
      if (!sec_ext_i) begin
         if (!rev2_i) begin
            view_o.pick_ns = 1'b1;
            view_o.mask    = LEGACY_MASK;
         end else begin
            view_o.mask        = SEC_MASK;
            view_o.alias_to_ns = 1'b1;
         end
      end else if (ns_i) begin
         view_o.pick_ns    = 1'b1;
         view_o.mask       = rev2_i ? NSEC_MASK : (NSEC_MASK & LEGACY_MASK);
         view_o.alias_to_s = rev2_i;
      end else begin
         view_o.mask        = SEC_MASK;
         view_o.alias_to_ns = 1'b1;
      end
   end
endmodule

// File: rtl/ciface_ctl_cell.sv
module ciface_ctl_cell
   import ciface_ctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  view_t             view_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] s_q_o,
   output logic [DATA_W-1:0] ns_q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_q_o  <= '0;
         ns_q_o <= '0;
      end else if (wr_i) begin
         if (view_i.pick_ns) begin
            ns_q_o <= wdata_i & view_i.mask;
            if (view_i.alias_to_s) s_q_o[1] <= wdata_i[0];
         end else begin
            s_q_o <= wdata_i & view_i.mask;
            if (view_i.alias_to_ns) ns_q_o[0] <= wdata_i[1];
         end
      end
   end
endmodule

// File: rtl/ciface_ctl_bank.sv
module ciface_ctl_bank
   import ciface_ctl_pkg::*;
#(
   parameter int               N_CPU     = 4,
   parameter int               CPU_IDX_W = 3,
   parameter int               OFF_W     = 12,
   parameter logic [OFF_W-1:0] CTL_OFF   = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sec_ext_i,
   input  logic                 rev2_i,
   input  logic                 acc_wr_i,
   input  logic                 acc_rd_i,
   input  logic [CPU_IDX_W-1:0] acc_cpu_i,
   input  logic [OFF_W-1:0]     acc_off_i,
   input  logic [31:0]          acc_wdata_i,
   input  logic                 acc_ns_i,
   output logic [31:0]          acc_rdata_o,
   output logic [N_CPU-1:0]     grp0_en_o,
   output logic [N_CPU-1:0]     grp1_en_o
);
   localparam int IDX_SPAN = 1 << CPU_IDX_W;

   generate
      if (N_CPU < 1 || N_CPU > 8) begin : g_bad_ncpu
         $error("N_CPU must lie between 1 and 8");
      end
      if (N_CPU > IDX_SPAN) begin : g_bad_idx
         $error("CPU_IDX_W too narrow for N_CPU");
      end
      if (DATA_W != 32) begin : g_bad_width
         $error("register width must be 32");
      end
   endgenerate

   view_t             view;
   logic              off_hit;
   logic [N_CPU-1:0]  cpu_sel;
   logic [31:0]       s_q   [N_CPU];
   logic [31:0]       ns_q  [N_CPU];
   logic [31:0]       rd_arr[N_CPU];
   logic [31:0]       rd_or;

   assign off_hit = (acc_off_i == CTL_OFF);

   ciface_ctl_view u_view (
      .sec_ext_i (sec_ext_i),
      .rev2_i    (rev2_i),
      .ns_i      (acc_ns_i),
      .view_o    (view)
   );

   for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
      assign cpu_sel[c] = (acc_cpu_i == CPU_IDX_W'(c));

      ciface_ctl_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_i    (acc_wr_i & off_hit & cpu_sel[c]),
         .view_i  (view),
         .wdata_i (acc_wdata_i),
         .s_q_o   (s_q[c]),
         .ns_q_o  (ns_q[c])
      );

      assign rd_arr[c]    = cpu_sel[c] ?
                            ((view.pick_ns ? ns_q[c] : s_q[c]) & view.mask) : '0;
      assign grp0_en_o[c] = s_q[c][0];
      assign grp1_en_o[c] = ns_q[c][0];
   end

   always_comb begin
      rd_or = '0;
      for (int c = 0; c < N_CPU; c++) rd_or = rd_or | rd_arr[c];
   end

   assign acc_rdata_o = (acc_rd_i && off_hit) ? rd_or : '0;
endmodule

// File: rtl/ciface_ctl_bank_chk.sv
module ciface_ctl_bank_chk
   import ciface_ctl_pkg::*;
#(
   parameter int               N_CPU     = 4,
   parameter int               CPU_IDX_W = 3,
   parameter int               OFF_W     = 12,
   parameter logic [OFF_W-1:0] CTL_OFF   = '0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sec_ext_i,
   input logic                 rev2_i,
   input logic                 acc_wr_i,
   input logic                 acc_rd_i,
   input logic [CPU_IDX_W-1:0] acc_cpu_i,
   input logic [OFF_W-1:0]     acc_off_i,
   input logic [31:0]          acc_wdata_i,
   input logic                 acc_ns_i,
   input logic [31:0]          acc_rdata_o,
   input logic [N_CPU-1:0]     grp0_en_o,
   input logic [N_CPU-1:0]     grp1_en_o
);
   localparam int SPAN = 1 << CPU_IDX_W;

   logic [SPAN-1:0] g0x, g1x;
   logic in_rng, hit, s_write, ns_write;

   assign g0x      = SPAN'(grp0_en_o);
   assign g1x      = SPAN'(grp1_en_o);
   assign in_rng   = ({1'b0, acc_cpu_i} < (CPU_IDX_W+1)'(N_CPU));
   assign hit      = (acc_off_i == CTL_OFF);
   assign s_write  = acc_wr_i && hit && in_rng &&
                     ((!sec_ext_i && rev2_i) || (sec_ext_i && !acc_ns_i));
   assign ns_write = acc_wr_i && hit && in_rng &&
                     ((!sec_ext_i && !rev2_i) || (sec_ext_i && acc_ns_i));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_reset_clear_r1: assert (grp0_en_o == '0 && grp1_en_o == '0);
      end
   end

   p_sec_grp0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      s_write |=> g0x[$past(acc_cpu_i)] == $past(acc_wdata_i[0]));

   p_sec_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
      s_write |=> g1x[$past(acc_cpu_i)] == $past(acc_wdata_i[1]));

   p_nsec_grp1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ns_write |=> g1x[$past(acc_cpu_i)] == $past(acc_wdata_i[0]));

   p_nsec_keeps_grp0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ns_write |=> $stable(grp0_en_o));

   p_oor_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr_i && !in_rng) |=> ($stable(grp0_en_o) && $stable(grp1_en_o)));

   p_oor_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd_i && !in_rng) |-> acc_rdata_o == '0);

   p_off_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr_i && !hit) |=> ($stable(grp0_en_o) && $stable(grp1_en_o)));

   p_off_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_rd_i || !hit) |-> acc_rdata_o == '0);

   p_legacy_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd_i && !rev2_i && (!sec_ext_i || acc_ns_i)) |-> acc_rdata_o[31:1] == '0);

   p_nsec_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd_i && sec_ext_i && acc_ns_i) |-> (acc_rdata_o & ~NSEC_MASK) == '0);

   p_sec_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rdata_o[31:11] == '0);
endmodule

bind ciface_ctl_bank ciface_ctl_bank_chk #(
   .N_CPU     (N_CPU),
   .CPU_IDX_W (CPU_IDX_W),
   .OFF_W     (OFF_W),
   .CTL_OFF   (CTL_OFF)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sec_ext_i   (sec_ext_i),
   .rev2_i      (rev2_i),
   .acc_wr_i    (acc_wr_i),
   .acc_rd_i    (acc_rd_i),
   .acc_cpu_i   (acc_cpu_i),
   .acc_off_i   (acc_off_i),
   .acc_wdata_i (acc_wdata_i),
   .acc_ns_i    (acc_ns_i),
   .acc_rdata_o (acc_rdata_o),
   .grp0_en_o   (grp0_en_o),
   .grp1_en_o   (grp1_en_o)
);

// File: tb/test_ciface_ctl_bank.sv
`timescale 1ns/1ps
module test_ciface_ctl_bank;
   localparam int N_CPU = 4;
   localparam int IDX_W = 3;
   localparam int SPAN  = 1 << IDX_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sec_ext_i = 1'b0, rev2_i = 1'b0;
   logic             acc_wr_i = 1'b0, acc_rd_i = 1'b0, acc_ns_i = 1'b0;
   logic [IDX_W-1:0] acc_cpu_i = '0;
   logic [11:0]      acc_off_i = '0;
   logic [31:0]      acc_wdata_i = '0;
   logic [31:0]      acc_rdata_o;
   logic [N_CPU-1:0] grp0_en_o, grp1_en_o;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [31:0] ms [SPAN];
   logic [31:0] mns[SPAN];

   always #2.5 clk = ~clk;

   ciface_ctl_bank #(.N_CPU(N_CPU), .CPU_IDX_W(IDX_W)) i_ciface_ctl_bank (
      .clk(clk), .rst_n(rst_n), .sec_ext_i(sec_ext_i), .rev2_i(rev2_i),
      .acc_wr_i(acc_wr_i), .acc_rd_i(acc_rd_i), .acc_cpu_i(acc_cpu_i),
      .acc_off_i(acc_off_i), .acc_wdata_i(acc_wdata_i), .acc_ns_i(acc_ns_i),
      .acc_rdata_o(acc_rdata_o), .grp0_en_o(grp0_en_o), .grp1_en_o(grp1_en_o));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic string read_tag(bit ns);
      if (!sec_ext_i && !rev2_i) return "R2";
      if (!sec_ext_i)            return "R3";
      if (ns)                    return "R4";
      return "R6";
   endfunction

   function automatic logic [31:0] exp_read(int cpu, bit ns);
      if (cpu >= N_CPU)          return '0;
      if (!sec_ext_i && !rev2_i) return mns[cpu] & 32'h1;
      if (!sec_ext_i)            return ms[cpu] & 32'h7FF;
      if (ns)                    return mns[cpu] & (rev2_i ? 32'h261 : 32'h1);
      return ms[cpu] & 32'h7FF;
   endfunction

   task automatic model_write(int cpu, bit ns, logic [31:0] d);
      if (cpu >= N_CPU) return;
      if (!sec_ext_i && !rev2_i) mns[cpu] = d & 32'h1;
      else if (sec_ext_i && ns) begin
         mns[cpu] = d & (rev2_i ? 32'h261 : 32'h1);
         if (rev2_i) ms[cpu][1] = d[0];
      end else begin
         ms[cpu]     = d & 32'h7FF;
         mns[cpu][0] = d[1];
      end
   endtask

   function automatic logic [31:0] exp_g0();
      logic [31:0] v = '0;
      for (int c = 0; c < N_CPU; c++) v[c] = ms[c][0];
      return v;
   endfunction

   function automatic logic [31:0] exp_g1();
      logic [31:0] v = '0;
      for (int c = 0; c < N_CPU; c++) v[c] = mns[c][0];
      return v;
   endfunction

   task automatic do_write(int cpu, bit ns, logic [11:0] off, logic [31:0] d);
      @(negedge clk);
      acc_rd_i = 0; acc_wr_i = 1; acc_cpu_i = IDX_W'(cpu);
      acc_ns_i = ns; acc_off_i = off; acc_wdata_i = d;
      @(negedge clk);
      acc_wr_i = 0;
   endtask

   task automatic do_read(int cpu, bit ns, logic [11:0] off, output logic [31:0] r);
      @(negedge clk);
      acc_wr_i = 0; acc_rd_i = 1; acc_cpu_i = IDX_W'(cpu);
      acc_ns_i = ns; acc_off_i = off;
      #1 r = acc_rdata_o;
      @(negedge clk);
      acc_rd_i = 0;
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 0;
      for (int c = 0; c < SPAN; c++) begin ms[c] = '0; mns[c] = '0; end
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   function automatic logic [31:0] pattern(int k, int cpu);
      case (k)
         0: return 32'hFFFF_FFFF;
         1: return 32'h0000_0002;
         2: return 32'h0000_0001;
         3: return 32'h0000_0000;
         default: return (32'h9E37_79B9 * (k * 8 + cpu + 1)) ^ 32'h0000_0263;
      endcase
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      for (int c = 0; c < SPAN; c++) begin ms[c] = '0; mns[c] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      check("R1 grp0", 32'(grp0_en_o), '0);
      check("R1 grp1", 32'(grp1_en_o), '0);
      for (int c = 0; c < N_CPU; c++)
         for (int ns = 0; ns < 2; ns++) begin
            do_read(c, ns[0], 12'h000, r);
            check("R1 read", r, '0);
         end

      for (int cfg = 0; cfg < 4; cfg++) begin
         @(negedge clk);
         rst_n = 0;
         sec_ext_i = cfg[1]; rev2_i = cfg[0];
         apply_reset();
         for (int k = 0; k < 6; k++)
            for (int cpu = 0; cpu < SPAN; cpu++)
               for (int ns = 0; ns < 2; ns++) begin
                  logic [31:0] d = pattern(k, cpu + ns);
                  do_write(cpu, ns[0], 12'h000, d);
                  model_write(cpu, ns[0], d);
                  // R7 and R10: every CPU's enables follow the model after the edge
                  check(cpu >= N_CPU ? "R8 grp0" : "R7 R10 grp0", 32'(grp0_en_o), exp_g0());
                  check(cpu >= N_CPU ? "R8 grp1" : "R7 R10 grp1", 32'(grp1_en_o), exp_g1());
                  for (int rn = 0; rn < 2; rn++) begin
                     do_read(cpu, rn[0], 12'h000, r);
                     if (cpu >= N_CPU) check("R8 read", r, '0);
                     else if (sec_ext_i && rev2_i && ns == 1 && rn == 0)
                        check("R5 secure view", r, exp_read(cpu, 1'b0));
                     else check(read_tag(rn[0]), r, exp_read(cpu, rn[0]));
                  end
               end
         // R9: other offsets are inert
         for (int cpu = 0; cpu < N_CPU; cpu++) begin
            do_write(cpu, 1'b0, 12'h004, 32'hFFFF_FFFF ^ ms[cpu]);
            do_write(cpu, 1'b1, 12'hFFC, 32'hFFFF_FFFF ^ mns[cpu]);
            check("R9 grp0", 32'(grp0_en_o), exp_g0());
            check("R9 grp1", 32'(grp1_en_o), exp_g1());
            do_read(cpu, 1'b0, 12'h004, r);
            check("R9 off read", r, '0);
            do_read(cpu, 1'b0, 12'h000, r);
            check("R9 kept", r, exp_read(cpu, 1'b0));
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule